// File: doc/BRIEF.md
# 8b/10b Symbol Encoder with Disparity Override

The block turns one byte plus a control flag into a 10-bit DC-balanced line symbol each enabled clock cycle. It keeps a running disparity bit and picks, for every sub-block, the code variant that drives the line back towards balance. The symbol, its valid flag and a control-code error flag come out of registers one cycle after the inputs are presented.

The running disparity used for the current symbol can be taken from an input instead of the internal register. This lets a link controller insert deliberate disparity errors or resynchronisation patterns. A combinational output gives the disparity that the current symbol will leave behind. Two copies can therefore be cross-wired into a 16-bit encoder: the high byte is encoded first and the low byte continues from the high byte's disparity in the same cycle. An idle request or an illegal control code produces the comma-bearing idle symbol K28.5.

Top module: `sym_encoder_8b10b`

## Requirements
- R1: While and after reset, `symbol` is 0, `sym_valid` and `ctrl_err` are 0, and `disp_q` is 0. A `disp_q` of 0 means negative running disparity and 1 means positive.
- R2: When `enable` is high, the symbol for the inputs appears on `symbol` after the next rising clock edge, with `sym_valid` high. `byte_in[4:0]` is the 5-bit group x and `byte_in[7:5]` is the 3-bit group y. `symbol[9:4]` is the 6-bit sub-block (abcdei, a at bit 9) and `symbol[3:0]` is the 4-bit sub-block (fghj, f at bit 3). Data codes follow the standard 8b/10b code tables.
- R3: Each symbol has 4, 5 or 6 ones. A symbol that starts from negative disparity has 5 or 6 ones, and one that starts from positive disparity has 4 or 5. The running disparity flips exactly when the symbol has a count of ones other than 5.
- R4: For D.x.7, the alternate 4-bit code (0111 at negative, 1000 at positive) is used where the primary code would form a run of five equal bits across bits e, i and f. This applies to x in {17,18,20} at negative disparity and x in {11,13,14} at positive disparity.
- R5: With `ctrl_in` high, the legal control codes are K28.0 to K28.7 and K23.7, K27.7, K29.7 and K30.7. They encode per the standard tables; for example, K28.5 is 0011111010 at negative disparity and 1100000101 at positive disparity.
- R6: An illegal control code is encoded as K28.5, and `ctrl_err` is high for exactly that output cycle.
- R7: With `idle_req` high, the output is K28.5 whatever `byte_in` and `ctrl_in` hold, and `ctrl_err` stays low.
- R8: With `disp_override` high, `disp_ext` replaces the internal disparity as the starting disparity. With `disp_ext` = 0 the symbol has 5 or 6 ones; with `disp_ext` = 1 it has 4 or 5 ones.
- R9: `disp_next` is combinational and gives the disparity after the symbol being encoded from the current inputs. `disp_q` takes that value on each enabled clock edge.
- R10: While `enable` is low, `symbol` and `disp_q` hold their values and `sym_valid` and `ctrl_err` are 0.
- R11: In the 16-bit wiring, the high instance's `disp_ext` takes the low instance's `disp_q`, and the low instance's `disp_ext` takes the high instance's `disp_next`. Both have `disp_override` high and share `enable`. The pair produces the same symbols as encoding the high byte and then the low byte back to back on one encoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Encode the inputs this cycle |
| byte_in | input | 8 | Byte to encode (HGF EDCBA) |
| ctrl_in | input | 1 | Byte is a control code |
| idle_req | input | 1 | Force the K28.5 idle symbol |
| disp_override | input | 1 | Use disp_ext as starting disparity |
| disp_ext | input | 1 | External starting disparity (1 = positive) |
| symbol | output | 10 | Encoded symbol, abcdei fghj from bit 9 down |
| sym_valid | output | 1 | Symbol updated this cycle |
| ctrl_err | output | 1 | Illegal control code was replaced |
| disp_q | output | 1 | Registered running disparity |
| disp_next | output | 1 | Combinational disparity after the current symbol |

## Verification
The encoder is driven with random bytes at both disparities. This covers the unbalanced, neutral and special-case (D.x.7, D.7.y, D.x.3) sub-blocks, so wrong table entries and wrong complement decisions are caught. Directed bytes hit the alternate-7 cases at each disparity, which separates a correct run-length rule from one applied at the wrong disparity. Control codes mixed with illegal ones and idle requests distinguish substitution from pass-through. Random override values, enable gaps and a cross-wired pair show whether the disparity source and the hold behaviour are right.

// File: rtl/sym_encoder_8b10b.sv
module sym_encoder_8b10b (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [7:0] byte_in,
  input  logic       ctrl_in,
  input  logic       idle_req,
  input  logic       disp_override,
  input  logic       disp_ext,
  output logic [9:0] symbol,
  output logic       sym_valid,
  output logic       ctrl_err,
  output logic       disp_q,
  output logic       disp_next
);

  function automatic logic [5:0] code6(input logic [4:0] v);
    case (v)
      5'd0:  code6 = 6'b100111;  5'd1:  code6 = 6'b011101;
      5'd2:  code6 = 6'b101101;  5'd3:  code6 = 6'b110001;
      5'd4:  code6 = 6'b110101;  5'd5:  code6 = 6'b101001;
      5'd6:  code6 = 6'b011001;  5'd7:  code6 = 6'b111000;
      5'd8:  code6 = 6'b111001;  5'd9:  code6 = 6'b100101;
      5'd10: code6 = 6'b010101;  5'd11: code6 = 6'b110100;
      5'd12: code6 = 6'b001101;  5'd13: code6 = 6'b101100;
      5'd14: code6 = 6'b011100;  5'd15: code6 = 6'b010111;
      5'd16: code6 = 6'b011011;  5'd17: code6 = 6'b100011;
      5'd18: code6 = 6'b010011;  5'd19: code6 = 6'b110010;
      5'd20: code6 = 6'b001011;  5'd21: code6 = 6'b101010;
      5'd22: code6 = 6'b011010;  5'd23: code6 = 6'b111010;
      5'd24: code6 = 6'b110011;  5'd25: code6 = 6'b100110;
      5'd26: code6 = 6'b010110;  5'd27: code6 = 6'b110110;
      5'd28: code6 = 6'b001110;  5'd29: code6 = 6'b101110;
      5'd30: code6 = 6'b011110;  default: code6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] code4(input logic [2:0] v);
    case (v)
      3'd0: code4 = 4'b1011;  3'd1: code4 = 4'b1001;
      3'd2: code4 = 4'b0101;  3'd3: code4 = 4'b1100;
      3'd4: code4 = 4'b1101;  3'd5: code4 = 4'b1010;
      3'd6: code4 = 4'b0110;  default: code4 = 4'b1110;
    endcase
  endfunction

  logic       disp_r, cur_rd, legal_k, bad_k, subst, use_k, k28;
  logic [4:0] x;
  logic [2:0] y;
  logic [5:0] c6n, c6;
  logic [3:0] c4n, c4;
  logic       bal6, flip6, rd_mid, alt7, kbal, flip4;

  assign cur_rd  = disp_override ? disp_ext : disp_r;
  assign legal_k = (byte_in[4:0] == 5'd28) ||
                   (byte_in[7:5] == 3'd7 && byte_in[4:0] inside {5'd23, 5'd27, 5'd29, 5'd30});
  assign bad_k   = ctrl_in && !legal_k && !idle_req;
  assign subst   = idle_req || bad_k;
  assign use_k   = ctrl_in || idle_req;
  assign x       = subst ? 5'd28 : byte_in[4:0];
  assign y       = subst ? 3'd5  : byte_in[7:5];
  assign k28     = use_k && (x == 5'd28);

  always_comb begin
    c6n    = k28 ? 6'b001111 : code6(x);
    bal6   = ($countones(c6n) == 3);
    flip6  = !bal6 || (c6n == 6'b111000);
    c6     = (cur_rd && flip6) ? ~c6n : c6n;
    rd_mid = bal6 ? cur_rd : ~cur_rd;
    alt7   = (y == 3'd7) && (use_k ||
             (!rd_mid && x inside {5'd17, 5'd18, 5'd20}) ||
             ( rd_mid && x inside {5'd11, 5'd13, 5'd14}));
    kbal   = k28 && (y inside {3'd1, 3'd2, 3'd5, 3'd6});
    c4n    = alt7 ? 4'b0111 : code4(y);
    if (kbal) c4n = ~c4n;
    flip4  = (y inside {3'd0, 3'd3, 3'd4, 3'd7}) || kbal;
    c4     = (rd_mid && flip4) ? ~c4n : c4n;
  end

  assign disp_next = (y inside {3'd0, 3'd4, 3'd7}) ? ~rd_mid : rd_mid;
  assign disp_q    = disp_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      symbol    <= '0;
      sym_valid <= 1'b0;
      ctrl_err  <= 1'b0;
      disp_r    <= 1'b0;
    end else if (enable) begin
      symbol    <= {c6, c4};
      sym_valid <= 1'b1;
      ctrl_err  <= bad_k;
      disp_r    <= disp_next;
    end else begin
      sym_valid <= 1'b0;
      ctrl_err  <= 1'b0;
    end
  end

  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> ($countones(symbol) >= 4 && $countones(symbol) <= 6)); // R3
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> disp_q == (($countones(symbol) == 5) ? $past(cur_rd) : ($countones(symbol) > 5))); // R3
  AST_FORCE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && disp_override && !disp_ext) |=> $countones(symbol) >= 5); // R8
  AST_FORCE_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && disp_override && disp_ext) |=> $countones(symbol) <= 5); // R8
  AST_CASCADE_REG: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> disp_q == $past(disp_next)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sym_valid && !ctrl_err && $stable(symbol) && $stable(disp_q))); // R10
  AST_IDLE_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && idle_req) |=> !ctrl_err); // R7
  AST_ERR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_err |-> sym_valid); // R6

endmodule

// File: tb/tb_sym_encoder_8b10b.sv
`timescale 1ns/1ps
module tb_sym_encoder_8b10b;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, k = 1'b0, idle = 1'b0, ov = 1'b0, ext = 1'b0;
  logic [7:0] b = '0;
  logic [9:0] sym;
  logic vld, err, dq, dn;
  int checks = 0, errors = 0;
  logic mrd = 1'b0;
  logic [9:0] msym = '0;

  always #2.5 clk = ~clk;

  sym_encoder_8b10b dut (.clk(clk), .rst_n(rst_n), .enable(en), .byte_in(b), .ctrl_in(k),
    .idle_req(idle), .disp_override(ov), .disp_ext(ext), .symbol(sym), .sym_valid(vld),
    .ctrl_err(err), .disp_q(dq), .disp_next(dn));

  logic ce = 1'b0, hk = 1'b0, lk = 1'b0;
  logic [7:0] hb = '0, lb = '0;
  logic [9:0] hs, ls;
  logic hv, he, hq, hn, lv, le, lq, ln;
  sym_encoder_8b10b u_hi (.clk(clk), .rst_n(rst_n), .enable(ce), .byte_in(hb), .ctrl_in(hk),
    .idle_req(1'b0), .disp_override(1'b1), .disp_ext(lq), .symbol(hs), .sym_valid(hv),
    .ctrl_err(he), .disp_q(hq), .disp_next(hn));
  sym_encoder_8b10b u_lo (.clk(clk), .rst_n(rst_n), .enable(ce), .byte_in(lb), .ctrl_in(lk),
    .idle_req(1'b0), .disp_override(1'b1), .disp_ext(hn), .symbol(ls), .sym_valid(lv),
    .ctrl_err(le), .disp_q(lq), .disp_next(ln));

  function automatic logic [5:0] t6(input logic [4:0] v);
    logic [5:0] tbl [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
      6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100,
      6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
      6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
      6'b011110, 6'b101011};
    return tbl[v];
  endfunction

  function automatic logic [11:0] ref_enc(input logic [7:0] bi, input logic ki, input logic id,
                                          input logic rd);
    logic [4:0] x; logic [2:0] y; logic e, kk, rm, rn;
    logic [9:0] s; logic [5:0] s6; logic [3:0] p;
    logic [9:0] k28 [8] = '{10'b0011110100, 10'b0011111001, 10'b0011110101, 10'b0011110011,
                            10'b0011110010, 10'b0011111010, 10'b0011110110, 10'b0011111000};
    logic [3:0] f4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    x = bi[4:0]; y = bi[7:5]; kk = ki | id; e = 1'b0;
    if (id) begin x = 5'd28; y = 3'd5; end
    else if (ki && !(x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)))) begin
      e = 1'b1; x = 5'd28; y = 3'd5;
    end
    if (kk && x == 28) begin
      s = rd ? ~k28[y] : k28[y];
    end else begin
      s6 = t6(x);
      if ($countones(s6) != 3 || s6 == 6'b111000) s6 = rd ? ~s6 : s6;
      rm = ($countones(s6) == 3) ? rd : ($countones(s6) > 3);
      p = f4[y];
      if ($countones(p) != 2 || y == 3) p = rm ? ~p : p;
      if (y == 7 && (kk || (s6[1] == s6[0] && s6[0] == p[3]))) p = rm ? 4'b1000 : 4'b0111;
      s = {s6, p};
    end
    rn = ($countones(s) == 5) ? rd : ($countones(s) > 5);
    return {e, rn, s};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e_i, input logic [7:0] b_i, input logic k_i, input logic id_i,
                     input logic ov_i, input logic ext_i, input string tag);
    logic cur; logic [11:0] r;
    @(negedge clk);
    en = e_i; b = b_i; k = k_i; idle = id_i; ov = ov_i; ext = ext_i;
    cur = ov_i ? ext_i : mrd;
    r = ref_enc(b_i, k_i, id_i, cur);
    #1;
    if (e_i) chk(dn, r[10], {tag, " R9 disp_next"});
    @(posedge clk); #1;
    if (e_i) begin
      msym = r[9:0]; mrd = r[10];
      chk(vld, 1, {tag, " R2 valid"});
      chk(err, r[11], {tag, " R6 ctrl_err"});
    end else begin
      chk(vld, 0, {tag, " R10 valid low"});
      chk(err, 0, {tag, " R10 err low"});
    end
    chk(sym, msym, {tag, " R2 symbol"});
    chk(dq, mrd, {tag, " R9 disp_q"});
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic crd; logic [11:0] rh, rl;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(sym, 0, "R1 symbol"); chk(vld, 0, "R1 valid");
    chk(err, 0, "R1 err");    chk(dq, 0, "R1 disp");
    @(negedge clk) rst_n = 1'b1;

    cyc(1, 8'hBC, 1, 0, 0, 0, "R5 K28.5 neg");
    chk(sym, 10'b0011111010, "R5 K28.5 RD- literal");
    cyc(1, 8'hBC, 1, 0, 0, 0, "R5 K28.5 pos");
    chk(sym, 10'b1100000101, "R5 K28.5 RD+ literal");
    cyc(1, 8'hB5, 0, 0, 1, 0, "R2 D21.5");
    chk(sym, 10'b1010101010, "R2 D21.5 literal");
    cyc(1, 8'hF1, 0, 0, 1, 0, "R4 D17.7 neg");
    chk(sym, 10'b1000110111, "R4 A7 at RD-");
    cyc(1, 8'hEB, 0, 0, 1, 1, "R4 D11.7 pos");
    chk(sym, 10'b1101001000, "R4 A7 at RD+");
    cyc(1, 8'hE3, 0, 0, 1, 0, "R4 D3.7 neg primary");
    chk(sym, 10'b1100011110, "R4 primary D3.7");
    cyc(1, 8'h00, 1, 0, 1, 0, "R6 illegal K0.0");
    chk(sym, 10'b0011111010, "R6 substituted K28.5");
    chk(err, 1, "R6 err set");
    cyc(1, 8'h00, 0, 0, 1, 0, "R6 err pulse ends");
    chk(err, 0, "R6 err one cycle");
    cyc(1, 8'h55, 1, 1, 1, 1, "R7 idle over bad K");
    chk(sym, 10'b1100000101, "R7 idle at RD+");
    chk(err, 0, "R7 no err");
    cyc(1, 8'hFE, 1, 0, 1, 0, "R5 K30.7");
    chk(sym, 10'b0111101000, "R5 K30.7 RD- literal");
    cyc(0, 8'h12, 1, 1, 0, 0, "R10 hold");
    cyc(0, 8'h99, 0, 0, 1, 1, "R10 hold again");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] rb; logic rk;
      rb = 8'($urandom); rk = ($urandom % 6) == 0;
      if (rk && ($urandom % 2)) rb = ($urandom % 2) ? {3'($urandom), 5'd28} : {3'd7, 5'd29};
      cyc(($urandom % 8) != 0, rb, rk, ($urandom % 25) == 0, ($urandom % 5) == 0,
          1'($urandom), "R3 random");
    end
    en = 1'b0;

    crd = 1'b0;
    for (int i = 0; i < 600; i++) begin
      logic e_i;
      @(negedge clk);
      e_i = ($urandom % 6) != 0;
      ce = e_i; hb = 8'($urandom); lb = 8'($urandom);
      hk = ($urandom % 10) == 0; lk = ($urandom % 10) == 0;
      if (hk) hb = 8'hBC;
      rh = ref_enc(hb, hk, 1'b0, crd);
      rl = ref_enc(lb, lk, 1'b0, rh[10]);
      @(posedge clk); #1;
      if (e_i) begin
        crd = rl[10];
        chk(hs, rh[9:0], "R11 high symbol");
        chk(ls, rl[9:0], "R11 low symbol");
      end
      chk(lq, crd, "R11 pair disparity");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule